// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational binary adder that forms every carry by lookahead instead of letting it ripple from bit to bit. Each bit position first derives a generate term (both operand bits set) and a propagate term (at least one operand bit set). The word is cut into groups of equal width. Each group condenses its bits into one group generate and one group propagate. A second-level unit turns those group terms and the adder's carry-in into the carry entering every group. Inside each group the carries into the individual bits are then formed by lookahead from the group's own bit terms and that incoming carry.

Every carry is written as a flat sum of products at its level. No gate therefore waits on another bit's carry, and the fan-in of any product stays within one group width or one group count. The block is used wherever a single-cycle add of two words plus an incoming carry is needed. The default build is 16 bits split into four 4-bit groups.

Top module: `cla_adder16`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of the integer sum `opnd_a + opnd_b + carry_in`, for every operand pair and both carry-in values.
- R2: `carry_out` equals bit WIDTH (bit 16 by default) of that same integer sum.
- R3: The carry that the second-level unit delivers into group k+1 equals the carry that group k produces from its own bits and its own incoming carry, at every group boundary. The last group's carry-out equals `carry_out`.
- R4: When every bit of a group has at least one operand bit set, that group's incoming carry reaches every bit position inside the group. For example, 0xFFFF + 0x0000 with carry-in 1 gives sum 0x0000 and carry-out 1.
- R5: A bit position where both operand bits are 1 produces a carry into the next position whatever its own incoming carry is. A group whose group generate is 1 produces a carry-out. For example, 0x8000 + 0x8000 gives sum 0x0000 and carry-out 1.
- R6: A bit position where both operand bits are 0 stops any carry. For example, 0x7FFF + 0x0000 with carry-in 1 gives 0x8000 with carry-out 0, and 0x0000 + 0x0000 with carry-in 0 gives 0x0000 with carry-out 0.
- R7: A carry generated in the lowest bit travels across every group boundary. For example, 0x0FFF + 0x0001 gives 0x1000, and 0x00FF + 0xFF01 gives 0x0000 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH (16) | First addend |
| opnd_b | input | WIDTH (16) | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds the block with its defaults, WIDTH of 16 and a group width of 4, so four groups meet the second-level unit across three inner boundaries. With a 4-bit group, the lowest group can be swept over every operand pair and both carry-in values in 512 vectors. That sweep reaches every mix of generate, propagate and kill bits that any group can see. Random full-width vectors and directed long propagate chains then push carries through all four groups at once, which is where a wrong group term or boundary carry would show.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Widest vector the lookahead functions accept (group width or group count).
  localparam int LA_MAX = 16;

  // Carry into position k of a chain, built as a flat sum of products:
  // any generate at j < k whose later propagates up to k-1 are all set,
  // or the chain's carry-in with all propagates below k set.
  function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                    input logic [LA_MAX-1:0] p,
                                    input logic              cin,
                                    input int                k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < LA_MAX; j++) begin
      if (j < k) begin
        term = g[j];
        for (int m = 0; m < LA_MAX; m++) begin
          if (m > j && m < k) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    term = cin;
    for (int m = 0; m < LA_MAX; m++) begin
      if (m < k) term = term & p[m];
    end
    return acc | term;
  endfunction

  // Group propagate: every one of the n low propagates set.
  function automatic logic la_prop(input logic [LA_MAX-1:0] p,
                                   input int                n);
    logic acc;
    acc = 1'b1;
    for (int m = 0; m < LA_MAX; m++) begin
      if (m < n) acc = acc & p[m];
    end
    return acc;
  endfunction

  // Group generate: the carry out of n positions with a zero carry-in.
  function automatic logic la_gen(input logic [LA_MAX-1:0] g,
                                  input logic [LA_MAX-1:0] p,
                                  input int                n);
    return la_carry(g, p, 1'b0, n);
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] half
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] | b[i];
    assign half[i] = a[i] ^ b[i];

    // A bit with both inputs set must not look like a kill.
    always_comb begin
      if (!$isunknown({a[i], b[i]}) && gen[i])
        AST_GEN_HAS_PROP: assert (prop[i] && !half[i]); // R5
    end
  end

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] gen,
  input  logic [GW-1:0] prop,
  input  logic [GW-1:0] half,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_gen,
  output logic          grp_prop,
  output logic          cout_local
);

  logic [LA_MAX-1:0] gen_pad;
  logic [LA_MAX-1:0] prop_pad;
  logic [GW-1:0]     carry;   // carry into each bit of the group

  always_comb begin
    gen_pad  = '0;
    prop_pad = '0;
    gen_pad[GW-1:0]  = gen;
    prop_pad[GW-1:0] = prop;
  end

  assign carry[0] = cin;
  for (genvar i = 1; i < GW; i++) begin : g_carry
    assign carry[i] = la_carry(gen_pad, prop_pad, cin, i);
  end

  assign sum        = half ^ carry;
  assign grp_gen    = la_gen(gen_pad, prop_pad, GW);
  assign grp_prop   = la_prop(prop_pad, GW);
  assign cout_local = la_carry(gen_pad, prop_pad, cin, GW);

  always_comb begin
    if (!$isunknown({gen, prop, cin})) begin
      if (grp_prop && cin)
        AST_GROUP_PASS: assert (&carry && cout_local); // R4
      if (grp_gen)
        AST_GROUP_GEN_OUT: assert (cout_local); // R5
      if (!grp_gen && !grp_prop)
        AST_GROUP_NO_OUT: assert (!cout_local); // R6
    end
  end

  for (genvar i = 0; i + 1 < GW; i++) begin : g_chk
    always_comb begin
      if (!$isunknown({gen, prop, cin})) begin
        if (gen[i])
          AST_BIT_GEN_CARRY: assert (carry[i+1]); // R5
        if (!prop[i])
          AST_BIT_KILL_CARRY: assert (!carry[i+1]); // R6
      end
    end
  end

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
  import cla_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic [NG-1:0] grp_gen,
  input  logic [NG-1:0] grp_prop,
  input  logic          cin,
  output logic [NG-1:0] grp_cin,
  output logic          cout
);

  logic [LA_MAX-1:0] gen_pad;
  logic [LA_MAX-1:0] prop_pad;

  always_comb begin
    gen_pad  = '0;
    prop_pad = '0;
    gen_pad[NG-1:0]  = grp_gen;
    prop_pad[NG-1:0] = grp_prop;
  end

  assign grp_cin[0] = cin;
  for (genvar k = 1; k < NG; k++) begin : g_gc
    assign grp_cin[k] = la_carry(gen_pad, prop_pad, cin, k);
  end
  assign cout = la_carry(gen_pad, prop_pad, cin, NG);

  for (genvar k = 0; k < NG; k++) begin : g_chk
    logic next_c;
    if (k + 1 < NG) begin : g_mid
      assign next_c = grp_cin[k+1];
    end else begin : g_top
      assign next_c = cout;
    end
    always_comb begin
      if (!$isunknown({grp_gen, grp_prop, cin})) begin
        if (grp_gen[k])
          AST_GROUP_GEN_FORCES: assert (next_c); // R5
        if (grp_prop[k] && grp_cin[k])
          AST_GROUP_PROP_PASSES: assert (next_c); // R4
      end
    end
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  localparam int NG = WIDTH / GROUP_W;

  logic [WIDTH-1:0] bit_gen;
  logic [WIDTH-1:0] bit_prop;
  logic [WIDTH-1:0] bit_half;
  logic [NG-1:0]    grp_gen;
  logic [NG-1:0]    grp_prop;
  logic [NG-1:0]    grp_cin;
  logic [NG-1:0]    grp_cout_local;

  cla_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a    (opnd_a),
    .b    (opnd_b),
    .gen  (bit_gen),
    .prop (bit_prop),
    .half (bit_half)
  );

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_group #(.GW(GROUP_W)) u_grp (
      .gen        (bit_gen [k*GROUP_W +: GROUP_W]),
      .prop       (bit_prop[k*GROUP_W +: GROUP_W]),
      .half       (bit_half[k*GROUP_W +: GROUP_W]),
      .cin        (grp_cin[k]),
      .sum        (sum_out [k*GROUP_W +: GROUP_W]),
      .grp_gen    (grp_gen[k]),
      .grp_prop   (grp_prop[k]),
      .cout_local (grp_cout_local[k])
    );
  end

  cla_carry_unit #(.NG(NG)) u_cu (
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop),
    .cin      (carry_in),
    .grp_cin  (grp_cin),
    .cout     (carry_out)
  );

  // Boundary agreement between the two lookahead levels.
  for (genvar k = 0; k + 1 < NG; k++) begin : g_bnd
    always_comb begin
      if (!$isunknown({opnd_a, opnd_b, carry_in}))
        AST_BOUNDARY_CARRY: assert (grp_cout_local[k] == grp_cin[k+1]); // R3
    end
  end

  logic [WIDTH:0] ref_total;
  always_comb begin
    ref_total = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
    if (!$isunknown({opnd_a, opnd_b, carry_in})) begin
      AST_TOP_COUT_MATCH: assert (grp_cout_local[NG-1] == carry_out); // R3
      AST_SUM_ARITH: assert (sum_out == ref_total[WIDTH-1:0]); // R1
      AST_COUT_ARITH: assert (carry_out == ref_total[WIDTH]); // R2
    end
  end

endmodule

// File: tb/cla_adder16_bench.sv
module cla_adder16_bench;

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    string       tag;
  } vec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_out;
  logic        carry_out;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  vec_t pending[$];

  always #10 clk = ~clk;  // 50 MHz

  cla_adder16 u_cla_adder16 (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

  // Reference: plain integer addition, compared on every clock.
  always @(posedge clk) begin
    if (!rst && pending.size() > 0) begin
      vec_t v;
      int   total;
      v = pending.pop_front();
      total = int'(v.a) + int'(v.b) + int'(v.cin);
      tests++;
      if (sum_out !== total[15:0]) begin
        fails++;
        $display("FAIL R1 %s: %h+%h+%0d sum got %h exp %h",
                 v.tag, v.a, v.b, v.cin, sum_out, total[15:0]);
      end
      tests++;
      if (carry_out !== total[16]) begin
        fails++;
        $display("FAIL R2 %s: %h+%h+%0d cout got %0d exp %0d",
                 v.tag, v.a, v.b, v.cin, carry_out, total[16]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input string tag);
    vec_t v;
    @(negedge clk);
    opnd_a   = a;
    opnd_b   = b;
    carry_in = cin;
    v.a = a; v.b = b; v.cin = cin; v.tag = tag;
    pending.push_back(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state: zero inputs give zero outputs (R6)
    drive(16'h0000, 16'h0000, 1'b0, "R6 reset zero");
    // Long propagate chains (R4)
    drive(16'hFFFF, 16'h0000, 1'b1, "R4 ffff+cin");
    drive(16'hFFFF, 16'h0001, 1'b0, "R4 ffff+1");
    drive(16'hAAAA, 16'h5555, 1'b1, "R4 alt prop");
    drive(16'hF0F0, 16'h0F0F, 1'b0, "R4 prop no cin");
    // Generate regardless of carry-in (R5)
    drive(16'h8000, 16'h8000, 1'b0, "R5 top gen");
    drive(16'h8000, 16'h8000, 1'b1, "R5 top gen cin");
    drive(16'h0008, 16'h0008, 1'b0, "R5 group gen");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 all gen");
    // Kill stops carry (R6)
    drive(16'h7FFF, 16'h0000, 1'b1, "R6 kill top");
    drive(16'hFFEF, 16'h0000, 1'b1, "R6 kill mid");
    // Boundary crossings (R7, R3)
    drive(16'h0FFF, 16'h0001, 1'b0, "R7 three bnd");
    drive(16'h00FF, 16'hFF01, 1'b0, "R7 full wrap");
    drive(16'h000F, 16'h0001, 1'b0, "R3 bnd0");
    drive(16'h00F0, 16'h0010, 1'b0, "R3 bnd1");
    drive(16'h0F00, 16'h0100, 1'b0, "R3 bnd2");
    // Exhaustive lowest group (R1, R2, R3)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          drive(16'(a), 16'(b), c[0], "R1 grp0 sweep");
    // Lowest group swept with upper bits all propagating (R3, R4)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        drive({12'hFFF, 4'(a)}, {12'h000, 4'(b)}, 1'b0, "R3 grp0 chain");
    // Random full-width (R1, R2)
    for (int i = 0; i < 3000; i++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule